// File: doc/BRIEF.md
# Serial Channel Host Register Block

This block is the processor-side control logic of a single asynchronous serial channel. A host reaches it over an 8-bit bus with a 3-bit address, an active-low select and active-low read and write strobes. Behind that bus sit two mode words that share one address, a command port, a status view and an interrupt mask. From these the block drives the channel's enable, reset and mode controls and an active-low interrupt line.

The serial shifters report their state back through simple level inputs: receiver ready, receiver full, transmitter ready, transmitter empty and a small vector of error flags. The block also takes the active-low clear-to-send line and gates the transmitter's start permission with it. Each access acts once, on the first clock edge that sees its strobe low with the select low. Read data is held in a register and driven onto the bus through a separate output-enable.

Top module: `sio_ctl_regs`

## Requirements
- R1: While cs_n is high, wr_n and rd_n have no effect: no register changes and d_oe stays low.
- R2: A read is captured on the first rising clock edge where cs_n and rd_n are both low. d_out then holds that value, and d_oe is high from that edge until rd_n or cs_n rises. d_oe is low before that edge.
- R3: Address 0 reaches two mode words through a pointer. Any read or write at address 0 while the pointer selects mode word A moves it to mode word B. Accesses to B leave the pointer where it is. The command nibble 0x1 in bits [7:4] of a command write returns the pointer to A.
- R4: chan_mode equals bits [7:6] of mode word B. echo_mode is high only when that field is 01.
- R5: A write to address 2 is a command word. Bit0 enables the receiver, bit1 disables it, bit2 enables the transmitter and bit3 disables it. Nibble 0x2 resets the receiver: it clears rx_en, pulses rx_rst for one cycle and clears held errors. Nibble 0x3 resets the transmitter: it clears tx_en and pulses tx_rst. Nibble 0x4 clears held errors. Several commands act in one write.
- R6: If a command word both enables a direction and also disables or resets that same direction, nothing is done for that direction. cmd_err is set and stays set until hardware reset. The other direction is still acted on. Bit0 of a read at address 2 returns cmd_err.
- R7: The receiver-disable command clears rx_en only. It leaves the status bits and the mode words unchanged.
- R8: Status at address 1 is laid out as {0, err[2:0], tx_empty, tx_ready, rx_full, rx_ready}, with bit0 being rx_ready. When bit5 of mode word A is 0, the error field follows err_in. When it is 1, each error bit is held once seen, until nibble 0x4 or nibble 0x2.
- R9: The interrupt status at address 4 is {err_any, rx_src, tx_empty, tx_ready}. rx_src is rx_ready when bit6 of mode word A is 0, and rx_full when it is 1.
- R10: The mask is written and read at address 5, bits [3:0]. irq_n goes low one clock after any interrupt status bit and its mask bit are both 1. A bit whose mask is 0 has no effect.
- R11: When bit4 of mode word B is 1, tx_start_ok is high only while tx_en is high and cts_n is low. When that bit is 0, tx_start_ok follows tx_en.
- R12: Hardware reset returns the pointer to mode word A and clears the mask, the held errors, tx_en, rx_en and cmd_err. After reset irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | AW | Register address |
| d_in | input | DW | Write data |
| d_out | output | DW | Registered read data |
| d_oe | output | 1 | Read data drive enable |
| rx_ready | input | 1 | Receiver holds a character |
| rx_full | input | 1 | Receiver storage full |
| tx_ready | input | 1 | Transmitter can accept a character |
| tx_empty | input | 1 | Transmitter idle and empty |
| err_in | input | ERR_W | Receive error flags |
| cts_n | input | 1 | Active-low clear-to-send |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| tx_rst | output | 1 | One-cycle transmitter reset pulse |
| rx_rst | output | 1 | One-cycle receiver reset pulse |
| chan_mode | output | 2 | Channel mode field |
| echo_mode | output | 1 | Automatic echo selected |
| tx_start_ok | output | 1 | Transmitter may start a character |
| cmd_err | output | 1 | Sticky rejected-command flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest state to reach from the ports is the held error field in block error mode, and in particular showing that a receiver disable leaves it alone while a receiver reset clears it. The stimulus first sets the block-mode bit through the pointer sequence. It then pulses an error input for one cycle and reads status after the input has dropped, so only the held copy can explain a set bit. After that it issues disable, error-reset and receiver-reset commands in turn, with a status read between each. Rejected commands are tested in the same way, by pairing a conflicting direction with a valid one in the same word.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam logic [2:0] A_MODE = 3'd0;
   localparam logic [2:0] A_STAT = 3'd1;
   localparam logic [2:0] A_CMD  = 3'd2;
   localparam logic [2:0] A_ISR  = 3'd4;
   localparam logic [2:0] A_IMR  = 3'd5;

   localparam logic [3:0] C_PTR   = 4'h1;
   localparam logic [3:0] C_RXRST = 4'h2;
   localparam logic [3:0] C_TXRST = 4'h3;
   localparam logic [3:0] C_ERRST = 4'h4;

   localparam int MA_IRQSEL = 6;
   localparam int MA_BLKERR = 5;
   localparam int MB_CTS    = 4;
   localparam int IRQ_W     = 4;

   typedef struct packed {
      logic rx_on;
      logic rx_off;
      logic rx_rst;
      logic tx_on;
      logic tx_off;
      logic tx_rst;
      logic ptr_rst;
      logic err_rst;
      logic bad;
   } cmd_t;
endpackage

// File: rtl/sio_bus_if.sv
module sio_bus_if #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [DW-1:0] rdata,
   output logic          wr_stb,
   output logic          rd_stb,
   output logic [DW-1:0] d_out,
   output logic          d_oe
);
   logic wr_lvl, rd_lvl, wr_q, rd_q;

   assign wr_lvl = !cs_n && !wr_n;
   assign rd_lvl = !cs_n && !rd_n;
   assign wr_stb = wr_lvl && !wr_q;
   assign rd_stb = rd_lvl && !rd_q;
   assign d_oe   = rd_q && rd_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= 1'b0;
         rd_q  <= 1'b0;
         d_out <= '0;
      end else begin
         wr_q <= wr_lvl;
         rd_q <= rd_lvl;
         if (rd_stb) d_out <= rdata;
      end
   end
endmodule

// File: rtl/sio_cmd_dec.sv
module sio_cmd_dec
   import sio_pkg::*;
(
   input  logic [7:0] cw,
   output cmd_t       cmd
);
   logic [3:0] nib;
   logic       rx_rq, tx_rq, rx_bad, tx_bad;

   always_comb begin
      nib    = cw[7:4];
      rx_rq  = (nib == C_RXRST);
      tx_rq  = (nib == C_TXRST);
      rx_bad = cw[0] && (cw[1] || rx_rq);
      tx_bad = cw[2] && (cw[3] || tx_rq);
      cmd.rx_on   = cw[0] && !rx_bad;
      cmd.rx_off  = cw[1] && !rx_bad;
      cmd.rx_rst  = rx_rq && !rx_bad;
      cmd.tx_on   = cw[2] && !tx_bad;
      cmd.tx_off  = cw[3] && !tx_bad;
      cmd.tx_rst  = tx_rq && !tx_bad;
      cmd.ptr_rst = (nib == C_PTR);
      cmd.err_rst = (nib == C_ERRST);
      cmd.bad     = rx_bad || tx_bad;
   end
endmodule

// File: rtl/sio_irq.sv
module sio_irq #(
   parameter int N       = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] isr,
   input  logic [N-1:0] imr,
   output logic         irq_n
);
   logic hit;
   assign hit = |(isr & imr);

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b1;
            else        irq_q <= !hit;
         end
         assign irq_n = irq_q;
      end else begin : g_comb
         assign irq_n = !hit;
      end
   endgenerate
endmodule

// File: rtl/sio_ctl_regs.sv
module sio_ctl_regs
   import sio_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 3,
   parameter int ERR_W   = 3,
   parameter bit REG_IRQ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    d_in,
   output logic [DW-1:0]    d_out,
   output logic             d_oe,
   input  logic             rx_ready,
   input  logic             rx_full,
   input  logic             tx_ready,
   input  logic             tx_empty,
   input  logic [ERR_W-1:0] err_in,
   input  logic             cts_n,
   output logic             tx_en,
   output logic             rx_en,
   output logic             tx_rst,
   output logic             rx_rst,
   output logic [1:0]       chan_mode,
   output logic             echo_mode,
   output logic             tx_start_ok,
   output logic             cmd_err,
   output logic             irq_n
);
   localparam int STAT_W = 4 + ERR_W;

   generate
      if (DW < 8) begin : g_bad_dw
         $error("sio_ctl_regs: DW must be at least 8");
      end
      if (AW < 3) begin : g_bad_aw
         $error("sio_ctl_regs: AW must be at least 3");
      end
      if (STAT_W > DW) begin : g_bad_err
         $error("sio_ctl_regs: ERR_W too wide for status word");
      end
   endgenerate

   logic              wr_stb, rd_stb;
   logic [DW-1:0]     rdata;
   logic [DW-1:0]     mra_q, mrb_q;
   logic              ptr_b;
   logic [IRQ_W-1:0]  imr_q, isr_w;
   logic [ERR_W-1:0]  err_acc, err_vis;
   logic              tx_en_q, rx_en_q, tx_rst_q, rx_rst_q, cmd_err_q;
   logic              blk_mode, rx_src;
   cmd_t              cmd;

   sio_bus_if #(.DW(DW)) u_bus (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .rdata(rdata), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .d_out(d_out), .d_oe(d_oe)
   );

   sio_cmd_dec u_dec (.cw(d_in[7:0]), .cmd(cmd));

   assign blk_mode = mra_q[MA_BLKERR];
   assign err_vis  = blk_mode ? err_acc : err_in;
   assign rx_src   = mra_q[MA_IRQSEL] ? rx_full : rx_ready;
   assign isr_w    = {|err_vis, rx_src, tx_empty, tx_ready};

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(A_MODE): rdata = ptr_b ? mrb_q : mra_q;
         AW'(A_STAT): rdata = DW'({err_vis, tx_empty, tx_ready, rx_full, rx_ready});
         AW'(A_CMD):  rdata = DW'(cmd_err_q);
         AW'(A_ISR):  rdata = DW'(isr_w);
         AW'(A_IMR):  rdata = DW'(imr_q);
         default:     rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mra_q     <= '0;
         mrb_q     <= '0;
         ptr_b     <= 1'b0;
         imr_q     <= '0;
         err_acc   <= '0;
         tx_en_q   <= 1'b0;
         rx_en_q   <= 1'b0;
         tx_rst_q  <= 1'b0;
         rx_rst_q  <= 1'b0;
         cmd_err_q <= 1'b0;
      end else begin
         tx_rst_q <= 1'b0;
         rx_rst_q <= 1'b0;
         err_acc  <= blk_mode ? (err_acc | err_in) : '0;
         if (rd_stb && addr == AW'(A_MODE)) ptr_b <= 1'b1;
         if (wr_stb) begin
            case (addr)
               AW'(A_MODE): begin
                  if (ptr_b) mrb_q <= d_in;
                  else begin
                     mra_q <= d_in;
                     ptr_b <= 1'b1;
                  end
               end
               AW'(A_IMR): imr_q <= d_in[IRQ_W-1:0];
               AW'(A_CMD): begin
                  if (cmd.rx_on)  rx_en_q <= 1'b1;
                  if (cmd.rx_off) rx_en_q <= 1'b0;
                  if (cmd.tx_on)  tx_en_q <= 1'b1;
                  if (cmd.tx_off) tx_en_q <= 1'b0;
                  if (cmd.rx_rst) begin
                     rx_en_q  <= 1'b0;
                     rx_rst_q <= 1'b1;
                     err_acc  <= '0;
                  end
                  if (cmd.tx_rst) begin
                     tx_en_q  <= 1'b0;
                     tx_rst_q <= 1'b1;
                  end
                  if (cmd.err_rst) err_acc   <= '0;
                  if (cmd.ptr_rst) ptr_b     <= 1'b0;
                  if (cmd.bad)     cmd_err_q <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   sio_irq #(.N(IRQ_W), .REG_OUT(REG_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .isr(isr_w), .imr(imr_q), .irq_n(irq_n)
   );

   assign tx_en       = tx_en_q;
   assign rx_en       = rx_en_q;
   assign tx_rst      = tx_rst_q;
   assign rx_rst      = rx_rst_q;
   assign cmd_err     = cmd_err_q;
   assign chan_mode   = mrb_q[7:6];
   assign echo_mode   = (mrb_q[7:6] == 2'b01);
   assign tx_start_ok = tx_en_q && (!mrb_q[MB_CTS] || !cts_n);
endmodule

// File: rtl/sio_ctl_chk.sv
module sio_ctl_chk #(
   parameter int N       = 4,
   parameter bit REG_IRQ = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cs_n,
   input logic         rd_n,
   input logic         d_oe,
   input logic         irq_n,
   input logic [N-1:0] isr,
   input logic [N-1:0] imr,
   input logic         cmd_err,
   input logic         tx_en,
   input logic         tx_rst,
   input logic         rx_en,
   input logic         rx_rst,
   input logic         cts_n,
   input logic         cts_chk,
   input logic         tx_start_ok
);
   p_bus_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !d_oe);

   p_oe_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      d_oe |-> (!rd_n && $past(!rd_n && !cs_n)));

   p_txrst_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rst |-> !tx_en);

   p_rxrst_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |-> !rx_en);

   p_cmd_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   p_cts_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_chk && cts_n) |-> !tx_start_ok);

   generate
      if (REG_IRQ) begin : g_irq
         p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (|(isr & imr)) |=> !irq_n);
         p_irq_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(isr & imr)) |=> irq_n);
      end
   endgenerate
endmodule

bind sio_ctl_regs sio_ctl_chk #(.N(sio_pkg::IRQ_W), .REG_IRQ(REG_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .d_oe(d_oe),
   .irq_n(irq_n), .isr(isr_w), .imr(imr_q), .cmd_err(cmd_err),
   .tx_en(tx_en), .tx_rst(tx_rst), .rx_en(rx_en), .rx_rst(rx_rst),
   .cts_n(cts_n), .cts_chk(mrb_q[sio_pkg::MB_CTS]), .tx_start_ok(tx_start_ok)
);

// File: tb/sim_sio_ctl_regs.sv
module sim_sio_ctl_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [2:0] addr = '0;
   logic [7:0] d_in = '0;
   logic [7:0] d_out;
   logic       d_oe;
   logic       rx_ready = 0, rx_full = 0, tx_ready = 0, tx_empty = 0;
   logic [2:0] err_in = '0;
   logic       cts_n = 1'b1;
   logic       tx_en, rx_en, tx_rst, rx_rst, echo_mode, tx_start_ok, cmd_err, irq_n;
   logic [1:0] chan_mode;

   int checks = 0;
   int errors = 0;
   logic seen_txrst, seen_rxrst;

   always #4 clk = ~clk;

   sio_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
      .rx_ready(rx_ready), .rx_full(rx_full), .tx_ready(tx_ready),
      .tx_empty(tx_empty), .err_in(err_in), .cts_n(cts_n),
      .tx_en(tx_en), .rx_en(rx_en), .tx_rst(tx_rst), .rx_rst(rx_rst),
      .chan_mode(chan_mode), .echo_mode(echo_mode),
      .tx_start_ok(tx_start_ok), .cmd_err(cmd_err), .irq_n(irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic hw_reset();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk) begin cs_n = 0; wr_n = 0; addr = a; d_in = d; end
      @(negedge clk) begin
         seen_txrst = tx_rst;
         seen_rxrst = rx_rst;
         cs_n = 1; wr_n = 1;
      end
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk) begin cs_n = 0; rd_n = 0; addr = a; end
      @(negedge clk) begin
         d = d_out;
         chk("R2 oe during read", d_oe, 1);
         cs_n = 1; rd_n = 1;
      end
   endtask

   task automatic set_modes(input logic [7:0] ma, input logic [7:0] mb);
      bus_wr(3'd2, 8'h10);
      bus_wr(3'd0, ma);
      bus_wr(3'd0, mb);
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      chk("R12 tx_en", tx_en, 0);
      chk("R12 rx_en", rx_en, 0);
      chk("R12 cmd_err", cmd_err, 0);
      chk("R12 irq_n", irq_n, 1);
      chk("R1 oe idle", d_oe, 0);
      bus_rd(3'd5, v);
      chk("R12 mask", v, 8'h00);
   endtask

   task automatic t_select();
      logic [7:0] v;
      @(negedge clk) begin cs_n = 1; wr_n = 0; addr = 3'd5; d_in = 8'h0F; end
      @(negedge clk) wr_n = 1;
      @(negedge clk) begin cs_n = 1; rd_n = 0; addr = 3'd5; end
      @(negedge clk) chk("R1 no oe without select", d_oe, 0);
      @(negedge clk) rd_n = 1;
      bus_rd(3'd5, v);
      chk("R1 write ignored", v, 8'h00);
   endtask

   task automatic t_read_timing();
      bus_wr(3'd5, 8'h06);
      @(negedge clk) begin cs_n = 0; rd_n = 0; addr = 3'd5; end
      #1 chk("R2 oe before edge", d_oe, 0);
      @(negedge clk) begin
         chk("R2 oe after edge", d_oe, 1);
         chk("R2 data", d_out, 8'h06);
      end
      @(negedge clk) chk("R2 oe held", d_oe, 1);
      rd_n = 1;
      #1 chk("R2 oe drops", d_oe, 0);
      bus_wr(3'd5, 8'h00);
   endtask

   task automatic t_pointer();
      logic [7:0] v;
      bus_wr(3'd0, 8'h60);
      bus_wr(3'd0, 8'h50);
      chk("R4 mode 01", chan_mode, 2'b01);
      chk("R4 echo", echo_mode, 1);
      bus_wr(3'd2, 8'h10);
      bus_rd(3'd0, v); chk("R3 first read A", v, 8'h60);
      bus_rd(3'd0, v); chk("R3 then B", v, 8'h50);
      bus_rd(3'd0, v); chk("R3 stays B", v, 8'h50);
      bus_wr(3'd0, 8'h80);
      chk("R4 mode 10", chan_mode, 2'b10);
      chk("R4 no echo", echo_mode, 0);
      bus_wr(3'd2, 8'h10);
      bus_rd(3'd0, v); chk("R3 A unchanged", v, 8'h60);
   endtask

   task automatic t_commands();
      bus_wr(3'd2, 8'h05);
      chk("R5 rx on", rx_en, 1); chk("R5 tx on", tx_en, 1);
      bus_wr(3'd2, 8'h0A);
      chk("R5 rx off", rx_en, 0); chk("R5 tx off", tx_en, 0);
      bus_wr(3'd2, 8'h05);
      bus_wr(3'd2, 8'h20);
      chk("R5 rx reset pulse", seen_rxrst, 1);
      chk("R5 rx reset clears", rx_en, 0);
      chk("R5 tx kept", tx_en, 1);
      @(negedge clk) chk("R5 pulse one cycle", rx_rst, 0);
      bus_wr(3'd2, 8'h30);
      chk("R5 tx reset pulse", seen_txrst, 1);
      chk("R5 tx reset clears", tx_en, 0);
   endtask

   task automatic t_conflict();
      logic [7:0] v;
      bus_wr(3'd2, 8'h34);
      chk("R6 tx untouched", tx_en, 0);
      chk("R6 no tx pulse", seen_txrst, 0);
      chk("R6 flag set", cmd_err, 1);
      bus_rd(3'd2, v);
      chk("R6 flag readable", v, 8'h01);
      bus_wr(3'd2, 8'h0D);
      chk("R6 other dir acts", rx_en, 1);
      chk("R6 conflicting dir idle", tx_en, 0);
      bus_wr(3'd2, 8'h02);
      chk("R6 flag sticky", cmd_err, 1);
   endtask

   task automatic t_errors();
      logic [7:0] v;
      rx_ready = 1;
      set_modes(8'h20, 8'h00);
      bus_wr(3'd2, 8'h01);
      @(negedge clk) err_in = 3'b010;
      @(negedge clk) err_in = 3'b000;
      bus_rd(3'd1, v); chk("R8 held error", v, 8'h21);
      bus_wr(3'd2, 8'h02);
      chk("R7 rx disabled", rx_en, 0);
      bus_rd(3'd1, v); chk("R7 status kept", v, 8'h21);
      bus_wr(3'd2, 8'h10);
      bus_rd(3'd0, v); chk("R7 mode kept", v, 8'h20);
      bus_wr(3'd2, 8'h40);
      bus_rd(3'd1, v); chk("R8 error reset", v, 8'h01);
      @(negedge clk) err_in = 3'b100;
      @(negedge clk) err_in = 3'b000;
      bus_wr(3'd2, 8'h20);
      bus_rd(3'd1, v); chk("R8 rx reset clears", v, 8'h01);
      set_modes(8'h00, 8'h00);
      @(negedge clk) err_in = 3'b101;
      bus_rd(3'd1, v); chk("R8 char mode follows", v, 8'h51);
      @(negedge clk) err_in = 3'b000;
      bus_rd(3'd1, v); chk("R8 char mode drops", v, 8'h01);
      rx_ready = 0;
   endtask

   task automatic t_irq();
      logic [7:0] v;
      rx_ready = 1;
      bus_wr(3'd5, 8'h04);
      @(negedge clk) chk("R10 irq on", irq_n, 0);
      bus_rd(3'd4, v); chk("R9 ready source", v, 8'h04);
      set_modes(8'h40, 8'h00);
      @(negedge clk) chk("R9 full source idle", irq_n, 1);
      rx_full = 1;
      @(negedge clk) chk("R9 full source", irq_n, 0);
      bus_wr(3'd5, 8'h0B);
      @(negedge clk) chk("R10 masked bit", irq_n, 1);
      tx_ready = 1;
      @(negedge clk) chk("R10 tx ready irq", irq_n, 0);
      bus_rd(3'd4, v); chk("R10 isr value", v, 8'h05);
      rx_ready = 0; rx_full = 0; tx_ready = 0;
      bus_wr(3'd5, 8'h00);
   endtask

   task automatic t_cts();
      set_modes(8'h00, 8'h10);
      bus_wr(3'd2, 8'h04);
      cts_n = 1;
      #1 chk("R11 blocked", tx_start_ok, 0);
      @(negedge clk) cts_n = 0;
      #1 chk("R11 allowed", tx_start_ok, 1);
      set_modes(8'h00, 8'h00);
      cts_n = 1;
      #1 chk("R11 ignored when off", tx_start_ok, 1);
   endtask

   task automatic t_hw_reset();
      logic [7:0] v;
      bus_wr(3'd5, 8'h0F);
      hw_reset();
      chk("R12 tx after reset", tx_en, 0);
      chk("R12 err flag cleared", cmd_err, 0);
      chk("R12 irq high", irq_n, 1);
      bus_rd(3'd5, v); chk("R12 mask cleared", v, 8'h00);
      bus_wr(3'd0, 8'h11);
      bus_wr(3'd2, 8'h10);
      bus_rd(3'd0, v); chk("R12 pointer at A", v, 8'h11);
      bus_rd(3'd0, v); chk("R12 B cleared", v, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      hw_reset();
      t_reset_state();
      t_select();
      t_read_timing();
      t_pointer();
      t_commands();
      t_conflict();
      t_errors();
      t_irq();
      t_cts();
      t_hw_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule